// File: doc/BRIEF.md
# Byte FIFO Mailbox Register Interface

This block sits between a processor's register bus and an embedded controller. Software sends bytes to the controller by writing a data register, which pushes into an outbound byte FIFO. The controller returns bytes through an inbound byte FIFO that software drains by reading the same data register. Both directions carry the byte in bits 15:8 of the 32-bit word. The controller side is a plain byte stream with valid/ready handshakes in each direction.

A status register keeps four sticky condition flags: outbound empty, outbound not full, inbound not empty and inbound overflow. A flag is set in every cycle its condition holds, and writing a one to its position clears it. An interrupt register holds a per-source enable for each flag and reflects the flags themselves as request bits. The interrupt line is the OR of every enabled flag.

Top module: `mbox_host_if`

## Requirements
- R1: After reset the interrupt line is low, `tx_valid` is low, `rx_ready` is high, and all four enable bits (interrupt register bits 7:4) read zero.
- R2: A write to byte offset 0x4 pushes `reg_wdata[15:8]` into the outbound FIFO; bytes leave on `tx_data` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R3: The outbound FIFO holds 8 bytes; a data write while it holds 8 is ignored and that byte never appears on `tx_data`.
- R4: A read of offset 0x4 pops the oldest inbound byte and returns it in bits 15:8 with all other bits zero; a read when the inbound FIFO is empty returns zero. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R5: `rx_ready` is low while the inbound FIFO holds 8 bytes; a byte offered with `rx_valid` high while `rx_ready` is low is dropped and sets the overflow flag (status bit 3), which stays set until cleared.
- R6: Status register (offset 0x8) bits are: bit 0 outbound empty, bit 1 outbound not full, bit 2 inbound not empty, bit 3 inbound overflow; each flag latches once its condition has held.
- R7: Writing ones to status bits clears those flags; a flag whose condition still holds sets again, so writing back the value just read leaves only conditions that are still true.
- R8: Interrupt register (offset 0x0) bits 7:4 are read/write enables for the four sources in the status bit order; bits 3:0 read the current status flags and ignore writes.
- R9: The `irq` output goes high one cycle after any flag whose enable bit is set is high, and low one cycle after no enabled flag remains.
- R10: Offsets 0xC to 0x1C read as zero, and writes to them change no register and push no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tx_data | output | 8 | Outbound byte to the controller |
| tx_valid | output | 1 | Outbound byte available |
| tx_ready | input | 1 | Controller takes the outbound byte |
| rx_data | input | 8 | Inbound byte from the controller |
| rx_valid | input | 1 | Controller offers an inbound byte |
| rx_ready | output | 1 | Inbound FIFO has room |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume reset is held for at least one clock, that `reg_wr` and `reg_rd` are never high together, and that offsets are word aligned, since the low two address bits are not decoded. The stimulus drives every register access as a single-cycle strobe on a falling edge with an aligned offset, and it changes `rx_valid`, `rx_data` and `tx_ready` only on falling edges, so each handshake is seen whole at the next rising edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned NFLAG   = 4;
  // word index of each register (byte offset / 4)
  localparam logic [2:0] IDX_IRQ  = 3'd0;
  localparam logic [2:0] IDX_DATA = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;
  // flag positions, shared by status, request and enable fields
  localparam int unsigned F_TXE  = 0;
  localparam int unsigned F_TXNF = 1;
  localparam int unsigned F_RXNE = 2;
  localparam int unsigned F_RXOV = 3;
  // byte lane inside the data word
  localparam int unsigned LANE_LO = 8;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = PW + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    fill;

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  assign dout  = store[rptr];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] enable,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[g] <= 1'b0;
      else if (cond[g]) flags[g] <= 1'b1;
      else if (clr[g])  flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & enable);
  end
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [BYTE_W-1:0]   tx_data,
  output logic                tx_valid,
  input  logic                tx_ready,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_valid,
  output logic                rx_ready,
  output logic                irq
);
  logic [2:0]        idx;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [BYTE_W-1:0] rx_head;
  logic [NFLAG-1:0]  cond, clr, flags_q, mask_q;

  assign idx = reg_addr[ADDR_W-1:2];

  assign tx_push = reg_wr && (idx == IDX_DATA) && !tx_full;
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && !rx_full;
  assign rx_pop  = reg_rd && (idx == IDX_DATA) && !rx_empty;

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push),
    .din(reg_wdata[LANE_LO +: BYTE_W]), .pop(tx_pop),
    .dout(tx_data), .empty(tx_empty), .full(tx_full)
  );

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_comb begin
    cond         = '0;
    cond[F_TXE]  = tx_empty;
    cond[F_TXNF] = !tx_full;
    cond[F_RXNE] = !rx_empty;
    cond[F_RXOV] = rx_valid && rx_full;
  end

  assign clr = (reg_wr && idx == IDX_STAT) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)                        mask_q <= '0;
    else if (reg_wr && idx == IDX_IRQ) mask_q <= reg_wdata[2*NFLAG-1:NFLAG];
  end

  mbox_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .cond(cond), .clr(clr),
    .enable(mask_q), .flags(flags_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (idx)
        IDX_IRQ:  reg_rdata[2*NFLAG-1:0] <= {mask_q, flags_q};
        IDX_DATA: if (!rx_empty) reg_rdata[LANE_LO +: BYTE_W] <= rx_head;
        IDX_STAT: reg_rdata[NFLAG-1:0] <= flags_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_host_if_chk.sv
module mbox_host_if_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  mask
);
  // R2: a stalled outbound byte is held unchanged
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R5: a byte refused by a full inbound FIFO raises overflow
  p_rx_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> flags[F_RXOV]);

  // R9: irq only follows an enabled flag of the previous cycle
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flags & mask)));

  // R9: an enabled flag raises irq on the next cycle
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    |(flags & mask) |=> irq);

  // R10: reserved offsets read zero
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd && (reg_addr[ADDR_W-1:2] > IDX_STAT) |=> reg_rdata == '0);
endmodule

bind mbox_host_if mbox_host_if_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .flags(flags_q), .mask(mask_q)
);

// File: tb/test_mbox_host_if.sv
module test_mbox_host_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  mbox_host_if i_mbox_host_if (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // read data is taken one cycle after the strobe (R4)
  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    rd(5'h00, v);
    check("R1 enables", v & 32'hF0, 32'h0);
    rd(5'h08, v);
    check("R6 idle status", v, 32'h3);
  endtask

  task automatic t_tx_order();
    tx_ready = 1'b0;
    wr(5'h04, 32'hFFFF_ABFF);
    wr(5'h04, 32'h0000_CD00);
    idle(1);
    check("R2 first byte valid", {31'b0, tx_valid}, 32'h1);
    check("R2 first byte", {24'b0, tx_data}, 32'hAB);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R2 second byte", {24'b0, tx_data}, 32'hCD);
    @(negedge clk);
    tx_ready = 1'b0;
    check("R2 drained", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_full_w1c();
    logic [31:0] v;
    tx_ready = 1'b0;
    for (int i = 0; i < 9; i++) wr(5'h04, 32'(8'h10 + i) << 8);
    idle(2);
    // outbound full: empty and not-full conditions gone, flags still latched
    rd(5'h08, v);
    check("R6 sticky flags", v, 32'h3);
    wr(5'h08, 32'hF);
    rd(5'h08, v);
    check("R7 clear while full", v, 32'h0);
    for (int i = 0; i < 8; i++) begin
      check("R3 byte held", {23'b0, tx_valid, tx_data}, 32'h100 | (32'h10 + i));
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    check("R3 ninth dropped", {31'b0, tx_valid}, 32'h0);
    idle(2);
    rd(5'h08, v);
    check("R6 reset on drain", v, 32'h3);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rx_send(8'h5A); rx_send(8'hC3); rx_send(8'h01);
    idle(2);
    rd(5'h08, v);
    check("R6 rx not empty", v, 32'h7);
    rd(5'h04, v); check("R4 pop 1", v, 32'h0000_5A00);
    rd(5'h04, v); check("R4 pop 2", v, 32'h0000_C300);
    rd(5'h04, v); check("R4 pop 3", v, 32'h0000_0100);
    rd(5'h04, v); check("R4 empty read", v, 32'h0);
    wr(5'h08, 32'h4);
    idle(1);
    rd(5'h08, v);
    check("R7 ack rx", v, 32'h3);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) rx_send(8'h80 + 8'(i));
    check("R5 ready low when full", {31'b0, rx_ready}, 32'h0);
    rx_send(8'hEE);
    idle(1);
    rd(5'h08, v);
    check("R5 overflow set", v, 32'hF);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, v);
      check("R5 kept byte", v, (32'h80 + i) << 8);
    end
    rd(5'h04, v);
    check("R5 dropped byte absent", v, 32'h0);
    idle(1);
    rd(5'h08, v);
    check("R5 overflow stays", v & 32'h8, 32'h8);
    wr(5'h08, v);
    idle(1);
    rd(5'h08, v);
    check("R7 write back", v, 32'h3);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(5'h00, 32'h0000_004F);  // enable rx-not-empty; low bits ignored
    idle(2);
    check("R9 no enabled source", {31'b0, irq}, 32'h0);
    rx_send(8'h33);
    idle(2);
    check("R9 irq on rx", {31'b0, irq}, 32'h1);
    rd(5'h00, v);
    check("R8 request and enable", v, 32'h47);
    rd(5'h04, v);
    wr(5'h08, 32'h4);
    idle(2);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h10);
    idle(2);
    check("R9 tx empty source", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h0);
    idle(2);
    check("R9 masked off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(5'h00, 32'hA0);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h0C, v); check("R10 read 0xC", v, 32'h0);
    rd(5'h1C, v); check("R10 read 0x1C", v, 32'h0);
    rd(5'h14, v); check("R10 read 0x14", v, 32'h0);
    rd(5'h00, v); check("R10 enables unchanged", v & 32'hF0, 32'hA0);
    check("R10 no byte pushed", {31'b0, tx_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);
    t_reset();
    t_tx_order();
    t_tx_full_w1c();
    t_rx();
    t_overflow();
    t_irq();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule